// File: doc/BRIEF.md
# Two-Step Single-Slope Conversion Sequencer

This column-level controller runs one conversion in two count phases. A global timing unit sends phase strobes and a free-running count shared by all columns. A comparator bit comes in from the analog side. In the first phase, against a steep ramp, the block captures a 3-bit coarse code. A reset interval follows, and a calibration window takes up the second part of that interval. The fine phase then runs against a shallow ramp at the same count rate and captures a 7-bit fine code. At the end the block joins the two codes into a 10-bit word and marks it with a single-cycle valid pulse.

The coarse code is driven out on its own pins from the moment it is latched. The residue stage uses it to choose a reference for each bit: a 1 selects the upper reference and a 0 selects the lower one. While the calibration window is open, an attached calibration unit sees a window strobe. During that window it may overwrite the coarse code, one write per cycle and as many times as needed. The final word always uses the coarse code as corrected.

Top module: `ts_conv_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle on that edge. After that edge `result_vld` and `cal_win` are 0 and `coarse_code` is 7.
- R2: Phases advance only in this order: idle, coarse, reset, calibration, fine, done, idle. `go_coarse` leaves idle, `go_reset` leaves coarse, `go_cal` leaves reset, `go_fine` leaves calibration and `go_done` leaves fine. A strobe that arrives in any other phase is ignored.
- R3: In the coarse phase, the first clock edge at which `cmp_in` differs from its value at the previous edge latches `cnt_in` as the coarse code, clamped to 7. Later toggles in the same phase are ignored.
- R4: If `cmp_in` does not toggle during the coarse phase, the coarse code is 7.
- R5: The fine code is captured the same way during the fine phase, clamped to 127. It is 127 when no toggle occurs.
- R6: `cal_win` is high exactly during the calibration phase.
- R7: `cal_wr` high during the calibration phase replaces the coarse code with `cal_code`. In any other phase `cal_wr` has no effect.
- R8: `coarse_code` presents the latched coarse code, including any calibration overwrite, from the edge that latches it until the next conversion starts.
- R9: The done phase lasts one cycle, with `result_vld` high. In that cycle `result` equals `coarse_code` shifted left by 7, ORed with the fine code. The block then returns to idle.
- R10: A comparator toggle in the same cycle as the strobe that ends its phase is still captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_in | input | 8 | Global count value |
| cmp_in | input | 1 | Comparator decision |
| go_coarse | input | 1 | Strobe: start coarse phase |
| go_reset | input | 1 | Strobe: end coarse phase, enter reset interval |
| go_cal | input | 1 | Strobe: open calibration window |
| go_fine | input | 1 | Strobe: start fine phase |
| go_done | input | 1 | Strobe: end fine phase |
| cal_wr | input | 1 | Calibration overwrite enable |
| cal_code | input | 3 | Corrected coarse code |
| coarse_code | output | 3 | Latched coarse code, drives reference selection |
| cal_win | output | 1 | Calibration window strobe |
| result | output | 10 | Combined conversion word |
| result_vld | output | 1 | One-cycle valid for `result` |

## Verification
Two events can fall in the same cycle in this block. In the first case, the comparator toggles on the very edge where the phase-ending strobe is accepted. In the second, the calibration unit writes in the last window cycle, together with `go_fine`. The bench sets the comparator threshold to the final count of a phase, and it places a calibration write alongside the fine strobe. It then judges that the toggle is still captured and that the written code reaches both `coarse_code` and the final word.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_COARSE, S_RESET, S_CAL, S_FINE, S_DONE
  } phase_t;

  // Clamp a count to the largest code a field can hold.
  function automatic logic [31:0] clamp_code(input logic [31:0] v, input logic [31:0] mx);
    return (v > mx) ? mx : v;
  endfunction

  // Join coarse and fine fields into one word (fine width fixed by caller).
  function automatic logic [31:0] join_word(input logic [31:0] c, input logic [31:0] f,
                                            input int unsigned fw);
    return (c << fw) | f;
  endfunction
endpackage

// File: rtl/tss_capture.sv
module tss_capture #(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              cmp,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ld,
  input  logic [CODE_W-1:0] ld_val,
  output logic [CODE_W-1:0] code,
  output logic              hit,
  output logic              flip
);
  import tss_pkg::*;
  localparam logic [31:0] MAXV = 32'((64'd1 << CODE_W) - 1);

  logic        cmp_q;
  logic [31:0] clamped;

  assign flip = en && !hit && (cmp != cmp_q);

  always_comb clamped = clamp_code(32'(cnt), MAXV);

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= MAXV[CODE_W-1:0];
      hit   <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      cmp_q <= cmp;
      if (clr) begin
        code <= MAXV[CODE_W-1:0];
        hit  <= 1'b0;
      end else if (ld) begin
        code <= ld_val;
      end else if (flip) begin
        code <= clamped[CODE_W-1:0];
        hit  <= 1'b1;
      end
    end
  end

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (hit && !clr && !ld) |=> $stable(code)); // R3
  AST_FLIP_MARKS: assert property (@(posedge clk) disable iff (rst)
    (flip && !clr) |=> hit); // R10
endmodule

// File: rtl/tss_fsm.sv
module tss_fsm (
  input  logic            clk,
  input  logic            rst,
  input  logic            go_coarse,
  input  logic            go_reset,
  input  logic            go_cal,
  input  logic            go_fine,
  input  logic            go_done,
  output tss_pkg::phase_t st,
  output logic            start_crs,
  output logic            start_fin
);
  import tss_pkg::*;
  phase_t nxt;

  assign start_crs = (st == S_IDLE) && go_coarse;
  assign start_fin = (st == S_CAL)  && go_fine;

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:   if (go_coarse) nxt = S_COARSE;
      S_COARSE: if (go_reset)  nxt = S_RESET;
      S_RESET:  if (go_cal)    nxt = S_CAL;
      S_CAL:    if (go_fine)   nxt = S_FINE;
      S_FINE:   if (go_done)   nxt = S_DONE;
      S_DONE:                  nxt = S_IDLE;
      default:                 nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= nxt;
  end

  AST_CAL_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    (st == S_CAL && $past(st) != S_CAL) |-> $past(st) == S_RESET); // R2
  AST_FINE_AFTER_CAL: assert property (@(posedge clk) disable iff (rst)
    (st == S_FINE && $past(st) != S_FINE) |-> $past(st) == S_CAL); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (st == S_DONE) |=> (st == S_IDLE)); // R9
endmodule

// File: rtl/ts_conv_seq.sv
module ts_conv_seq #(
  parameter int unsigned CRS_W = 3,
  parameter int unsigned FIN_W = 7,
  parameter int unsigned CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CNT_W-1:0]       cnt_in,
  input  logic                   cmp_in,
  input  logic                   go_coarse,
  input  logic                   go_reset,
  input  logic                   go_cal,
  input  logic                   go_fine,
  input  logic                   go_done,
  input  logic                   cal_wr,
  input  logic [CRS_W-1:0]       cal_code,
  output logic [CRS_W-1:0]       coarse_code,
  output logic                   cal_win,
  output logic [CRS_W+FIN_W-1:0] result,
  output logic                   result_vld
);
  import tss_pkg::*;
  localparam int unsigned RES_W = CRS_W + FIN_W;

  phase_t             st;
  logic               start_crs, start_fin;
  logic               crs_hit, crs_flip, fin_hit, fin_flip;
  logic               cal_load;
  logic [FIN_W-1:0]   fine_code;
  logic [31:0]        word;

  tss_fsm u_fsm (
    .clk(clk), .rst(rst),
    .go_coarse(go_coarse), .go_reset(go_reset), .go_cal(go_cal),
    .go_fine(go_fine), .go_done(go_done),
    .st(st), .start_crs(start_crs), .start_fin(start_fin)
  );

  assign cal_win  = (st == S_CAL);
  assign cal_load = cal_win && cal_wr;

  tss_capture #(.CODE_W(CRS_W), .CNT_W(CNT_W)) u_crs (
    .clk(clk), .rst(rst), .clr(start_crs), .en(st == S_COARSE),
    .cmp(cmp_in), .cnt(cnt_in), .ld(cal_load), .ld_val(cal_code),
    .code(coarse_code), .hit(crs_hit), .flip(crs_flip)
  );

  tss_capture #(.CODE_W(FIN_W), .CNT_W(CNT_W)) u_fin (
    .clk(clk), .rst(rst), .clr(start_fin), .en(st == S_FINE),
    .cmp(cmp_in), .cnt(cnt_in), .ld(1'b0), .ld_val('0),
    .code(fine_code), .hit(fin_hit), .flip(fin_flip)
  );

  always_comb word = join_word(32'(coarse_code), 32'(fine_code), FIN_W);

  assign result     = word[RES_W-1:0];
  assign result_vld = (st == S_DONE);

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    result_vld |=> !result_vld); // R9
  AST_COARSE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (st == S_FINE && $past(st) == S_FINE) |-> $stable(coarse_code)); // R8
  AST_WIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    cal_win |-> !(crs_flip || fin_flip)); // R6
endmodule

// File: tb/tb_ts_conv_seq.sv
module tb_ts_conv_seq;
  logic       clk = 0;
  logic       rst = 1;
  logic [7:0] cnt_in = 0;
  logic       cmp_in = 0;
  logic       go_coarse = 0, go_reset = 0, go_cal = 0, go_fine = 0, go_done = 0;
  logic       cal_wr = 0;
  logic [2:0] cal_code = 0;
  logic [2:0] coarse_code;
  logic       cal_win;
  logic [9:0] result;
  logic       result_vld;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit ended = 0;

  ts_conv_seq dut (
    .clk(clk), .rst(rst), .cnt_in(cnt_in), .cmp_in(cmp_in),
    .go_coarse(go_coarse), .go_reset(go_reset), .go_cal(go_cal),
    .go_fine(go_fine), .go_done(go_done), .cal_wr(cal_wr), .cal_code(cal_code),
    .coarse_code(coarse_code), .cal_win(cal_win), .result(result), .result_vld(result_vld)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
      finish_run();
    end
  end

  function automatic int model(input int th, input int n, input int mx);
    if (th < n) return (th > mx) ? mx : th;
    return mx;
  endfunction

  // One full conversion; cal_last puts a write together with go_fine.
  task automatic conv(input int cth, input int n1, input int fth, input int n2,
                      input bit do_cal, input int cv, input bit stray_wr);
    int ec = model(cth, n1, 7);
    int ef = model(fth, n2, 127);
    go_coarse = 1; cmp_in = 0; cnt_in = 0;
    @(negedge clk); go_coarse = 0;
    for (int k = 0; k < n1; k++) begin
      cnt_in = 8'(k); cmp_in = (k >= cth);
      go_reset = (k == n1 - 1);
      @(negedge clk);
    end
    go_reset = 0; cmp_in = 0; cnt_in = 0;
    chk("R3 coarse code in reset phase", coarse_code, ec);
    chk("R6 window closed in reset phase", cal_win, 0);
    @(negedge clk);
    go_cal = 1; @(negedge clk); go_cal = 0;
    chk("R6 window open", cal_win, 1);
    @(negedge clk);
    if (do_cal) begin cal_wr = 1; cal_code = 3'(cv); ec = cv; end
    go_fine = 1; @(negedge clk);
    go_fine = 0; cal_wr = 0;
    chk("R6 window closed in fine phase", cal_win, 0);
    chk("R7 coarse code after window", coarse_code, ec);
    for (int k = 0; k < n2; k++) begin
      cnt_in = 8'(k); cmp_in = (k >= fth);
      if (stray_wr) begin cal_wr = 1; cal_code = 3'(~ec); end
      go_done = (k == n2 - 1);
      @(negedge clk);
    end
    go_done = 0; cal_wr = 0; cmp_in = 0;
    chk("R9 valid in done cycle", result_vld, 1);
    chk("R9 R5 result word", result, (ec << 7) | ef);
    chk("R8 coarse pins at done", coarse_code, ec);
    @(negedge clk);
    chk("R9 valid drops", result_vld, 0);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R1 valid low after reset", result_vld, 0);
    chk("R1 window low after reset", cal_win, 0);
    chk("R1 coarse code after reset", coarse_code, 7);
  endtask

  task automatic t_stray_strobes();
    go_reset = 1; go_cal = 1; go_fine = 1; go_done = 1;
    @(negedge clk);
    go_reset = 0; go_cal = 0; go_fine = 0; go_done = 0;
    chk("R2 stray strobes: no window", cal_win, 0);
    chk("R2 stray strobes: no valid", result_vld, 0);
    @(negedge clk);
    chk("R2 stray strobes: still no valid", result_vld, 0);
  endtask

  task automatic t_mid_reset();
    go_coarse = 1; @(negedge clk); go_coarse = 0;
    for (int k = 0; k < 3; k++) begin
      cnt_in = 8'(k); cmp_in = (k >= 1); @(negedge clk);
    end
    rst = 1; @(negedge clk); rst = 0; cmp_in = 0;
    chk("R1 mid reset coarse code", coarse_code, 7);
    go_cal = 1; @(negedge clk); go_cal = 0;
    chk("R1 R2 idle after reset ignores go_cal", cal_win, 0);
  endtask

  initial begin
    t_reset();
    conv(3, 10, 40, 130, 0, 0, 0);    // R3 R5 mid-range
    conv(20, 10, 200, 220, 0, 0, 0);  // R4 no coarse toggle, R5 fine clamp
    conv(9, 12, 0, 130, 0, 0, 0);     // R3 clamp to 7, fine code 0
    conv(5, 6, 99, 100, 0, 0, 0);     // R10 toggles on the ending strobes
    conv(2, 10, 50, 130, 1, 6, 0);    // R7 write with go_fine
    conv(4, 10, 60, 200, 0, 0, 1);    // R7 stray writes in fine ignored
    conv(1, 10, 128, 135, 0, 0, 0);   // R5 fine clamp at 127
    t_stray_strobes();
    conv(0, 10, 10, 20, 0, 0, 0);     // R2 works after stray strobes
    t_mid_reset();
    conv(6, 10, 70, 130, 1, 1, 0);    // R8 calibrated code reaches result
    finish_run();
  end
endmodule